// File: doc/BRIEF.md
# Single-Cycle Decode and Execute Slice with Array-Index and Zero-Test Extensions

This block is the combinational heart of a single-cycle 32-bit RISC-V datapath. It takes the fetched instruction, its program counter, the two values read from the register file and the word returned by data memory. From these it produces the full set of datapath strobes, the ALU result (which is also the memory address and the branch target) and the value to write back to the destination register. The register file, instruction memory and data memory are outside the block, and the surrounding pipeline logic acts on the strobes the block produces.

Alongside a base subset of the integer instructions (register add and subtract, add-immediate, word load, word store and the six conditional branches), the slice decodes two custom register-format instructions from the custom-0 major opcode (`0001011`).

- `iarrn` (funct3 `000`, funct7 `0000000`) forms the byte address of element `rs2` of a word array based at `rs1`. It does this through an extra path on the ALU's second operand that shifts `rs2` left by two bits.
- `isnull` (funct3 `001`) writes 1 when `rs1` is zero and 0 otherwise. It reuses the branch comparator, with a hard zero in place of the second operand, and routes the equality result through the writeback mux.

Top module: `rvx_exec_slice`

## Requirements

The following encodings apply throughout:

- `wbSel`: 0 selects the memory word, 1 selects the ALU result, 2 selects the zero-extended zero-test bit.
- `aluSel`: 0 is add, 1 is subtract.
- `aSel`: 0 selects `rs1Val`, 1 selects `pc`.
- `bSel`: 0 selects `rs2Val`, 1 selects the immediate.

Requirements:

- R1: Opcode `0110011` with funct3 `000` gives `rs1Val+rs2Val` when funct7 is `0000000`, and `rs1Val-rs2Val` when funct7 is `0100000`. For both, `wbValue` equals the result, `regWen`=1, `memRw`=0, `pcSel`=0, `wbSel`=1, `aSel`=0 and `bSel`=0.
- R2: Opcode `0010011` with funct3 `000` gives `rs1Val` plus the sign-extended immediate in bits 31:20, with `bSel`=1 and `wbSel`=1.
- R3: Opcode `0000011` with funct3 `010` puts `rs1Val` plus the sign-extended I-immediate on `aluResult`, and `memRdata` on `wbValue`. It drives `wbSel`=0, `regWen`=1 and `memRw`=0.
- R4: Opcode `0100011` with funct3 `010` puts `rs1Val` plus the sign-extended S-immediate (bits 31:25 and 11:7) on `aluResult`. It drives `memRw`=1, `regWen`=0 and `wbSel`=0.
- R5: Opcode `1100011` drives `aluResult` = `pc` plus the B-immediate, with `aSel`=1, `bSel`=1, `regWen`=0, `wbSel`=1 and `brUn` equal to funct3 bit 1. `pcSel` is 1 exactly when the condition holds: funct3 `000` equal, `001` not equal, `100`/`110` less than, `101`/`111` greater or equal. The comparison is signed unless `brUn`=1.
- R6: `iarrn` drives `aluResult` and `wbValue` to `rs1Val + 4*rs2Val` modulo 2^32. The two top bits of `rs2Val` are discarded by the shift.
- R7: `iarrn` drives `pcSel`=0, `regWen`=1, `memRw`=0, `wbSel`=1, `aluSel`=0 and `aSel`=0.
- R8: `iArrN` is 1 only for `iarrn`. Every other encoding, including custom-0 funct3 `000` with a nonzero funct7, drives it to 0.
- R9: `isnull` drives `wbValue` to 1 when `rs1Val` is zero and to 0 otherwise, whatever `rs2Val` holds. It also drives `wbSel`=2, `regWen`=1, `memRw`=0 and `pcSel`=0.
- R10: Any encoding not listed above drives every control output (`pcSel`, `regWen`, `memRw`, `wbSel`, `brUn`, `aSel`, `bSel`, `aluSel`, `iArrN`) to 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction being executed |
| pc | input | 32 | Address of that instruction |
| rs1Val | input | 32 | First register-file read value |
| rs2Val | input | 32 | Second register-file read value |
| memRdata | input | 32 | Word returned by data memory |
| pcSel | output | 1 | 1 selects the ALU result as next PC, 0 selects PC+4 |
| regWen | output | 1 | Register-file write enable |
| memRw | output | 1 | 1 writes data memory |
| wbSel | output | 2 | Writeback source select |
| brUn | output | 1 | Unsigned comparison select |
| aSel | output | 1 | ALU first-operand select |
| bSel | output | 1 | ALU second-operand select |
| aluSel | output | 1 | ALU operation select |
| iArrN | output | 1 | Array-index instruction flag |
| aluResult | output | 32 | ALU output, also address and branch target |
| wbValue | output | 32 | Value to write to the destination register |

## Verification

The hardest case to reach from the ports is telling apart a zero test that really compares against a hard zero from one that compares `rs1Val` with `rs2Val`. Both give the same answer whenever `rs2Val` is zero or differs from a nonzero `rs1Val`.

The stimulus therefore feeds `isnull` equal nonzero values on both operands. It also sweeps `rs2Val` while `rs1Val` is zero.

In the same way, `iarrn` is given an `rs2Val` with its top bits set. The dropped bits must then disappear from the sum, which separates a true two-bit shift from a multiply that carries into a wider result.

// File: rtl/rvx_pkg.sv
package rvx_pkg;

  localparam int unsigned INSTR_W = 32;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_CUST0  = 7'b0001011;

  localparam logic [2:0] F3_IARRN  = 3'b000;
  localparam logic [2:0] F3_ISNULL = 3'b001;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [1:0] {
    WB_MEM  = 2'd0,
    WB_ALU  = 2'd1,
    WB_ZERO = 2'd2
  } wbSel_e;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } aluOp_e;

  typedef enum logic [1:0] {
    IMM_I = 2'd0,
    IMM_S = 2'd1,
    IMM_B = 2'd2
  } immSel_e;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    logic    pcSel;
    logic    regWen;
    logic    memRw;
    wbSel_e  wbSel;
    logic    brUn;
    logic    aSel;
    logic    bSel;
    aluOp_e  aluSel;
    logic    iArrN;
    logic    zeroTest;
    immSel_e immSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/rvx_ctrl.sv
module rvx_ctrl
  import rvx_pkg::*;
(
  input  logic [6:0]   opcode,
  input  logic [2:0]   funct3,
  input  logic [6:0]   funct7,
  input  logic         brEq,
  input  logic         brLt,
  output ctrlStrobes_t strobes
);

  logic takeBranch;
  logic branchLegal;

  // Branch condition from funct3; codes 010 and 011 are not branches
  always_comb begin
    takeBranch  = 1'b0;
    branchLegal = 1'b1;
    unique case (funct3)
      3'b000:         takeBranch = brEq;
      3'b001:         takeBranch = !brEq;
      3'b100, 3'b110: takeBranch = brLt;
      3'b101, 3'b111: takeBranch = !brLt;
      default:        branchLegal = 1'b0;
    endcase
  end

  always_comb begin
    strobes = '0;
    unique case (opcode)
      OPC_REG: begin
        if (funct3 == 3'b000 && (funct7 == F7_BASE || funct7 == F7_ALT)) begin
          strobes.regWen = 1'b1;
          strobes.wbSel  = WB_ALU;
          strobes.aluSel = (funct7 == F7_ALT) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_IMM: begin
        if (funct3 == 3'b000) begin
          strobes.regWen = 1'b1;
          strobes.wbSel  = WB_ALU;
          strobes.bSel   = 1'b1;
          strobes.immSel = IMM_I;
        end
      end
      OPC_LOAD: begin
        if (funct3 == 3'b010) begin
          strobes.regWen = 1'b1;
          strobes.wbSel  = WB_MEM;
          strobes.bSel   = 1'b1;
          strobes.immSel = IMM_I;
        end
      end
      OPC_STORE: begin
        if (funct3 == 3'b010) begin
          strobes.memRw  = 1'b1;
          strobes.bSel   = 1'b1;
          strobes.immSel = IMM_S;
        end
      end
      OPC_BRANCH: begin
        if (branchLegal) begin
          strobes.pcSel  = takeBranch;
          strobes.wbSel  = WB_ALU;
          strobes.aSel   = 1'b1;
          strobes.bSel   = 1'b1;
          strobes.brUn   = funct3[1];
          strobes.immSel = IMM_B;
        end
      end
      OPC_CUST0: begin
        if (funct3 == F3_IARRN && funct7 == F7_BASE) begin
          strobes.regWen = 1'b1;
          strobes.wbSel  = WB_ALU;
          strobes.iArrN  = 1'b1;
        end else if (funct3 == F3_ISNULL) begin
          strobes.regWen   = 1'b1;
          strobes.wbSel    = WB_ZERO;
          strobes.zeroTest = 1'b1;
        end
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/rvx_imm.sv
module rvx_imm
  import rvx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSTR_W-1:7] instrHi,
  input  immSel_e            immSel,
  output logic [XLEN-1:0]    immVal
);

  localparam int unsigned EXT_I = XLEN - 12;
  localparam int unsigned EXT_B = XLEN - 13;

  always_comb begin
    unique case (immSel)
      IMM_S:   immVal = {{EXT_I{instrHi[31]}}, instrHi[31:25], instrHi[11:7]};
      IMM_B:   immVal = {{EXT_B{instrHi[31]}}, instrHi[31], instrHi[7],
                         instrHi[30:25], instrHi[11:8], 1'b0};
      default: immVal = {{EXT_I{instrHi[31]}}, instrHi[31:20]};
    endcase
  end

endmodule

// File: rtl/rvx_cmp.sv
module rvx_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic            unsignedCmp,
  output logic            isEq,
  output logic            isLt
);

  always_comb begin
    isEq = (lhs == rhs);
    if (unsignedCmp) isLt = (lhs < rhs);
    else             isLt = ($signed(lhs) < $signed(rhs));
  end

endmodule

// File: rtl/rvx_datapath.sv
module rvx_datapath
  import rvx_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ELEM_SHIFT = 2
) (
  input  logic [INSTR_W-1:7] instrHi,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    rs1Val,
  input  logic [XLEN-1:0]    rs2Val,
  input  logic [XLEN-1:0]    memRdata,
  input  ctrlStrobes_t       strobes,
  output logic               brEq,
  output logic               brLt,
  output logic [XLEN-1:0]    aluResult,
  output logic [XLEN-1:0]    wbValue
);

  logic [XLEN-1:0] immVal;
  logic [XLEN-1:0] cmpRhs;
  logic [XLEN-1:0] opA;
  logic [XLEN-1:0] opB;
  logic [XLEN-1:0] scaledIdx;

  rvx_imm #(.XLEN(XLEN)) u_imm (
    .instrHi (instrHi),
    .immSel  (strobes.immSel),
    .immVal  (immVal)
  );

  // Zero test substitutes a hard-wired zero register for rs2
  assign cmpRhs = strobes.zeroTest ? '0 : rs2Val;

  rvx_cmp #(.XLEN(XLEN)) u_cmp (
    .lhs         (rs1Val),
    .rhs         (cmpRhs),
    .unsignedCmp (strobes.brUn),
    .isEq        (brEq),
    .isLt        (brLt)
  );

  assign scaledIdx = rs2Val << ELEM_SHIFT;

  always_comb begin
    opA = strobes.aSel ? pc : rs1Val;
    if (strobes.iArrN) opB = scaledIdx;
    else               opB = strobes.bSel ? immVal : rs2Val;
    aluResult = (strobes.aluSel == ALU_SUB) ? (opA - opB) : (opA + opB);
  end

  always_comb begin
    unique case (strobes.wbSel)
      WB_ALU:  wbValue = aluResult;
      WB_ZERO: wbValue = {{(XLEN-1){1'b0}}, brEq};
      default: wbValue = memRdata;
    endcase
  end

endmodule

// File: rtl/rvx_exec_slice.sv
module rvx_exec_slice
  import rvx_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ELEM_SHIFT = 2
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [XLEN-1:0] memRdata,
  output logic            pcSel,
  output logic            regWen,
  output logic            memRw,
  output logic [1:0]      wbSel,
  output logic            brUn,
  output logic            aSel,
  output logic            bSel,
  output logic            aluSel,
  output logic            iArrN,
  output logic [XLEN-1:0] aluResult,
  output logic [XLEN-1:0] wbValue
);

  ctrlStrobes_t strobes;
  logic         brEq;
  logic         brLt;

  rvx_ctrl u_ctrl (
    .opcode  (instr[6:0]),
    .funct3  (instr[14:12]),
    .funct7  (instr[31:25]),
    .brEq    (brEq),
    .brLt    (brLt),
    .strobes (strobes)
  );

  rvx_datapath #(.XLEN(XLEN), .ELEM_SHIFT(ELEM_SHIFT)) u_dp (
    .instrHi   (instr[31:7]),
    .pc        (pc),
    .rs1Val    (rs1Val),
    .rs2Val    (rs2Val),
    .memRdata  (memRdata),
    .strobes   (strobes),
    .brEq      (brEq),
    .brLt      (brLt),
    .aluResult (aluResult),
    .wbValue   (wbValue)
  );

  assign pcSel  = strobes.pcSel;
  assign regWen = strobes.regWen;
  assign memRw  = strobes.memRw;
  assign wbSel  = strobes.wbSel;
  assign brUn   = strobes.brUn;
  assign aSel   = strobes.aSel;
  assign bSel   = strobes.bSel;
  assign aluSel = strobes.aluSel;
  assign iArrN  = strobes.iArrN;

endmodule

// File: rtl/rvx_exec_slice_chk.sv
module rvx_exec_slice_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [31:0]     instr,
  input logic [XLEN-1:0] rs1Val,
  input logic [XLEN-1:0] rs2Val,
  input logic            pcSel,
  input logic            regWen,
  input logic            memRw,
  input logic [1:0]      wbSel,
  input logic            aSel,
  input logic            aluSel,
  input logic            iArrN,
  input logic [XLEN-1:0] aluResult,
  input logic [XLEN-1:0] wbValue
);

  logic knownOpc;
  assign knownOpc = (instr[6:0] == 7'b0110011) || (instr[6:0] == 7'b0010011) ||
                    (instr[6:0] == 7'b0000011) || (instr[6:0] == 7'b0100011) ||
                    (instr[6:0] == 7'b1100011) || (instr[6:0] == 7'b0001011);

  always_comb begin
    if (iArrN) begin
      p_iarrn_sum_r6: assert (aluResult == rs1Val + (rs2Val << 2) && wbValue == aluResult)
        else $error("iarrn sum mismatch");
      p_iarrn_ctl_r7: assert (!pcSel && regWen && !memRw && wbSel == 2'd1 && !aluSel && !aSel)
        else $error("iarrn strobes wrong");
      p_iarrn_only_r8: assert (instr[6:0] == 7'b0001011 && instr[14:12] == 3'b000 &&
                               instr[31:25] == 7'b0000000)
        else $error("iArrN raised for another encoding");
    end
    if (wbSel == 2'd2) begin
      p_zero_test_r9: assert (wbValue == {{(XLEN-1){1'b0}}, (rs1Val == '0)})
        else $error("zero test writeback wrong");
    end
    if (pcSel) begin
      p_redirect_branch_r5: assert (instr[6:0] == 7'b1100011 && !regWen)
        else $error("redirect outside a branch");
    end
    if (!knownOpc) begin
      p_unknown_quiet_r10: assert (!regWen && !memRw && !pcSel && !iArrN)
        else $error("unknown opcode not quiet");
    end
  end

endmodule

bind rvx_exec_slice rvx_exec_slice_chk #(.XLEN(XLEN)) u_chk (
  .instr     (instr),
  .rs1Val    (rs1Val),
  .rs2Val    (rs2Val),
  .pcSel     (pcSel),
  .regWen    (regWen),
  .memRw     (memRw),
  .wbSel     (wbSel),
  .aSel      (aSel),
  .aluSel    (aluSel),
  .iArrN     (iArrN),
  .aluResult (aluResult),
  .wbValue   (wbValue)
);

// File: tb/rvx_exec_slice_test.sv
`timescale 1ns/1ps
module rvx_exec_slice_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] instr, pc, rs1Val, rs2Val, memRdata;
  logic        pcSel, regWen, memRw, brUn, aSel, bSel, aluSel, iArrN;
  logic [1:0]  wbSel;
  logic [31:0] aluResult, wbValue;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rvx_exec_slice uut (
    .instr(instr), .pc(pc), .rs1Val(rs1Val), .rs2Val(rs2Val), .memRdata(memRdata),
    .pcSel(pcSel), .regWen(regWen), .memRw(memRw), .wbSel(wbSel), .brUn(brUn),
    .aSel(aSel), .bSel(bSel), .aluSel(aluSel), .iArrN(iArrN),
    .aluResult(aluResult), .wbValue(wbValue)
  );

  // ctl packing: {pcSel,regWen,memRw,wbSel[1:0],aluSel,bSel,aSel,brUn,iArrN}
  typedef struct packed {
    logic [6:0]  op;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [12:0] imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] pcv;
    logic [31:0] mem;
    logic [31:0] expAlu;
    logic [31:0] expWb;
    logic [9:0]  expCtl;
    logic        chkAlu;
    logic        chkWb;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    // R1 add
    '{7'b0110011, 3'b000, 7'b0000000, 13'd0, 32'd5, 32'd7, 32'h0, 32'h0,
      32'd12, 32'd12, 10'b0_1_0_01_0_0_0_0_0, 1'b1, 1'b1, 8'd1},
    // R1 sub
    '{7'b0110011, 3'b000, 7'b0100000, 13'd0, 32'd5, 32'd7, 32'h0, 32'h0,
      32'hFFFFFFFE, 32'hFFFFFFFE, 10'b0_1_0_01_1_0_0_0_0, 1'b1, 1'b1, 8'd1},
    // R2 addi -3
    '{7'b0010011, 3'b000, 7'b0, 13'h0FFD, 32'd10, 32'd99, 32'h0, 32'h0,
      32'd7, 32'd7, 10'b0_1_0_01_0_1_0_0_0, 1'b1, 1'b1, 8'd2},
    // R3 load
    '{7'b0000011, 3'b010, 7'b0, 13'd8, 32'h100, 32'd0, 32'h0, 32'h0000CAFE,
      32'h108, 32'h0000CAFE, 10'b0_1_0_00_0_1_0_0_0, 1'b1, 1'b1, 8'd3},
    // R4 store -4
    '{7'b0100011, 3'b010, 7'b0, 13'h0FFC, 32'h200, 32'h55, 32'h0, 32'h0,
      32'h1FC, 32'h0, 10'b0_0_1_00_0_1_0_0_0, 1'b1, 1'b1, 8'd4},
    // R5 beq taken
    '{7'b1100011, 3'b000, 7'b0, 13'd16, 32'd3, 32'd3, 32'h1000, 32'h0,
      32'h1010, 32'h1010, 10'b1_0_0_01_0_1_1_0_0, 1'b1, 1'b1, 8'd5},
    // R5 bne not taken
    '{7'b1100011, 3'b001, 7'b0, 13'd16, 32'd3, 32'd3, 32'h1000, 32'h0,
      32'h1010, 32'h1010, 10'b0_0_0_01_0_1_1_0_0, 1'b1, 1'b1, 8'd5},
    // R5 blt signed taken
    '{7'b1100011, 3'b100, 7'b0, 13'h1FF8, 32'hFFFFFFFF, 32'd1, 32'h1000, 32'h0,
      32'h0FF8, 32'h0FF8, 10'b1_0_0_01_0_1_1_0_0, 1'b1, 1'b1, 8'd5},
    // R5 bltu not taken
    '{7'b1100011, 3'b110, 7'b0, 13'h1FF8, 32'hFFFFFFFF, 32'd1, 32'h1000, 32'h0,
      32'h0FF8, 32'h0FF8, 10'b0_0_0_01_0_1_1_1_0, 1'b1, 1'b1, 8'd5},
    // R5 bge taken
    '{7'b1100011, 3'b101, 7'b0, 13'd4, 32'd1, 32'hFFFFFFFF, 32'h20, 32'h0,
      32'h24, 32'h24, 10'b1_0_0_01_0_1_1_0_0, 1'b1, 1'b1, 8'd5},
    // R6/R7 iarrn
    '{7'b0001011, 3'b000, 7'b0000000, 13'd0, 32'h400, 32'd5, 32'h0, 32'h0,
      32'h414, 32'h414, 10'b0_1_0_01_0_0_0_0_1, 1'b1, 1'b1, 8'd6},
    // R6 iarrn wrap, top index bits dropped
    '{7'b0001011, 3'b000, 7'b0000000, 13'd0, 32'hFFFFFFF0, 32'h40000005, 32'h0, 32'h0,
      32'h4, 32'h4, 10'b0_1_0_01_0_0_0_0_1, 1'b1, 1'b1, 8'd6},
    // R9 isnull zero
    '{7'b0001011, 3'b001, 7'b0, 13'd0, 32'h0, 32'h12345678, 32'h0, 32'hDEAD,
      32'h0, 32'd1, 10'b0_1_0_10_0_0_0_0_0, 1'b0, 1'b1, 8'd9},
    // R9 isnull nonzero equal to rs2
    '{7'b0001011, 3'b001, 7'b0, 13'd0, 32'h80000000, 32'h80000000, 32'h0, 32'hDEAD,
      32'h0, 32'd0, 10'b0_1_0_10_0_0_0_0_0, 1'b0, 1'b1, 8'd9},
    // R10 unknown opcode
    '{7'b1111111, 3'b000, 7'b0, 13'd0, 32'd1, 32'd2, 32'h0, 32'h0,
      32'h0, 32'h0, 10'b0, 1'b0, 1'b0, 8'd10},
    // R10 custom-0 unused funct3
    '{7'b0001011, 3'b010, 7'b0, 13'd0, 32'd1, 32'd2, 32'h0, 32'h0,
      32'h0, 32'h0, 10'b0, 1'b0, 1'b0, 8'd10},
    // R8/R10 iarrn slot with nonzero funct7
    '{7'b0001011, 3'b000, 7'b0000001, 13'd0, 32'd1, 32'd2, 32'h0, 32'h0,
      32'h0, 32'h0, 10'b0, 1'b0, 1'b0, 8'd8}
  };

  function automatic logic [31:0] mkInstr(input logic [6:0] op, input logic [2:0] f3,
                                          input logic [6:0] f7, input logic [12:0] imm);
    case (op)
      7'b0010011, 7'b0000011: mkInstr = {imm[11:0], 5'd6, f3, 5'd5, op};
      7'b0100011: mkInstr = {imm[11:5], 5'd7, 5'd6, f3, imm[4:0], op};
      7'b1100011: mkInstr = {imm[12], imm[10:5], 5'd7, 5'd6, f3, imm[4:1], imm[11], op};
      default:    mkInstr = {f7, 5'd7, 5'd6, f3, 5'd5, op};
    endcase
  endfunction

  function automatic logic [9:0] ctlNow();
    ctlNow = {pcSel, regWen, memRw, wbSel, aluSel, bSel, aSel, brUn, iArrN};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] p, input logic [31:0] m);
    @(posedge clk);
    instr = i; rs1Val = a; rs2Val = b; pc = p; memRdata = m;
    @(negedge clk);
  endtask

  initial begin
    instr = '0; pc = '0; rs1Val = '0; rs2Val = '0; memRdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all-zero instruction word is an unknown opcode (R10)
    check("R10 reset ctl", {22'd0, ctlNow()}, 32'd0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      apply(mkInstr(VECS[k].op, VECS[k].f3, VECS[k].f7, VECS[k].imm),
            VECS[k].a, VECS[k].b, VECS[k].pcv, VECS[k].mem);
      check($sformatf("R%0d vec%0d ctl", VECS[k].req, k), {22'd0, ctlNow()},
            {22'd0, VECS[k].expCtl});
      if (VECS[k].chkAlu)
        check($sformatf("R%0d vec%0d alu", VECS[k].req, k), aluResult, VECS[k].expAlu);
      if (VECS[k].chkWb)
        check($sformatf("R%0d vec%0d wb", VECS[k].req, k), wbValue, VECS[k].expWb);
    end

    // R9: rs2 has no influence when rs1 is zero or nonzero
    for (int s = 0; s < 8; s++) begin
      apply(mkInstr(7'b0001011, 3'b001, 7'b0, 13'd0), 32'h0, 32'h1 << (s * 4), 32'h0, 32'hFFFF);
      check("R9 sweep zero", wbValue, 32'd1);
      apply(mkInstr(7'b0001011, 3'b001, 7'b0, 13'd0), 32'h1 << (s * 4), 32'h0, 32'h0, 32'hFFFF);
      check("R9 sweep nonzero", wbValue, 32'd0);
    end

    // R8: iArrN low for every base instruction
    apply(mkInstr(7'b0110011, 3'b000, 7'b0, 13'd0), 32'd1, 32'd1, 32'h0, 32'h0);
    check("R8 add iArrN", {31'd0, iArrN}, 32'd0);
    apply(mkInstr(7'b0100011, 3'b010, 7'b0, 13'd0), 32'd1, 32'd1, 32'h0, 32'h0);
    check("R8 store iArrN", {31'd0, iArrN}, 32'd0);

    // R6: largest index wraps modulo 2^32
    apply(mkInstr(7'b0001011, 3'b000, 7'b0, 13'd0), 32'h8, 32'hFFFFFFFF, 32'h0, 32'h0);
    check("R6 max index", wbValue, 32'h4);

    // R1 sub borrow edge, R5 branch-to-self with bgeu equal
    apply(mkInstr(7'b0110011, 3'b000, 7'b0100000, 13'd0), 32'h0, 32'h80000000, 32'h0, 32'h0);
    check("R1 sub min", aluResult, 32'h80000000);
    apply(mkInstr(7'b1100011, 3'b111, 7'b0, 13'd0), 32'h7, 32'h7, 32'h40, 32'h0);
    check("R5 bgeu equal pcSel", {31'd0, pcSel}, 32'd1);
    check("R5 bgeu target", aluResult, 32'h40);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule